// File: doc/BRIEF.md
# Banked DRAM Controller with CAS-before-RAS Refresh

This block turns 64-bit read and write requests into multiplexed row/column cycles on an asynchronous DRAM array of up to eight banks. A request carries a byte address, a write flag, a per-32-bit write mask and write data. The block splits the address into bank, row and column according to the configured bank size. It then sequences one bank's row strobe, the column strobes and the write enable over a 12-bit multiplexed address bus. It computes one parity bit for each 32-bit half of the data it writes, and checks the parity that comes back with the data it reads.

A refresh timer, with an interval set by software configuration, requests CAS-before-RAS refresh cycles. A refresh waits for the access in progress to end and then goes ahead of any waiting request. A separate mode puts self-refreshing parts into self refresh: the block issues the CAS-before-RAS entry and holds every strobe low until the mode is cleared. The memory data bus is given as separate in, out and output-enable signals, so the pad ring above can build the bidirectional pins.

Top module: `dram_ctl`

## Requirements
- R1: After reset all row strobes, column strobes and the write enable are high (inactive), `req_ready` is 1 and `rd_valid` is 0.
- R2: `cfg_bank_size` 0, 1 and 2 select 2 MB, 8 MB and 32 MB banks. With W = `req_addr`>>3 and H = 9, 10 and 11 respectively, the column is W[H-1:0], the row is W[2H-1:H] and the bank is W[2H+2:2H]. Address bits above the bank field are ignored.
- R3: An accepted access runs as follows: one cycle with the row address on `mem_addr` and all row strobes high; one cycle with the row address and the row strobe of the decoded bank low; one cycle with the column address and that strobe still low; then max(`cfg_cas_hold`,1) cycles with the column strobes low; then max(`cfg_precharge`,1) cycles with every strobe high. At most one row strobe is low at any time outside refresh.
- R4: A read asserts all four column strobes. A write asserts `mem_cas_n[1:0]` when `req_wmask[0]` is 1 (lower 32 bits) and `mem_cas_n[3:2]` when `req_wmask[1]` is 1. During the column and CAS cycles of a write, `mem_we_n` is 0, `mem_dq_oe` is 1 and `mem_dq_o` carries the write data.
- R5: Read data is sampled at the last CAS cycle. It is presented on `rd_data`, with `rd_valid` high for exactly one cycle, in the first precharge cycle.
- R6: `mem_par_o[h]` equals the XOR of bits [32h+31:32h] of the write data, which is even parity when the parameter PAR_ODD is 0.
- R7: `rd_par_err[h]` is 1, together with `rd_valid`, exactly when `mem_par_i[h]` differs from the parity of the read half h. It is 0 whenever `rd_valid` is 0.
- R8: A refresh drives all column strobes low for one cycle with every row strobe high. It then drives all eight row strobes low together, with the column strobes still low, for max(`cfg_cas_hold`,1) cycles. A precharge of max(`cfg_precharge`,1) cycles follows. `mem_we_n` stays high throughout.
- R9: With a non-zero `cfg_ref_interval` and no traffic, a refresh starts every `cfg_ref_interval` cycles. A value of 0 stops periodic refresh.
- R10: A refresh that becomes due during an access begins as soon as the controller returns to idle, ahead of a pending request, and `req_ready` is 0 while it is due.
- R11: Setting `cfg_self_refresh` while idle issues the CAS-before-RAS entry and then holds every row and column strobe low, with `req_ready` at 0, until the bit clears. A precharge period follows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_bank_size | input | 2 | Bank size select: 0 = 2 MB, 1 = 8 MB, 2 = 32 MB |
| cfg_cas_hold | input | 3 | Column strobe hold cycles (0 treated as 1) |
| cfg_precharge | input | 3 | Precharge cycles (0 treated as 1) |
| cfg_ref_interval | input | 16 | Refresh period in cycles, 0 = off |
| cfg_self_refresh | input | 1 | Enter and hold self refresh |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request accepted this cycle when valid |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 28 | Byte address |
| req_wmask | input | 2 | Write enable per 32-bit half |
| req_wdata | input | 64 | Write data |
| rd_valid | output | 1 | Read data valid pulse |
| rd_data | output | 64 | Read data |
| rd_par_err | output | 2 | Parity mismatch per 32-bit half |
| mem_addr | output | 12 | Multiplexed row/column address |
| mem_ras_n | output | 8 | Row strobes, one per bank, active low |
| mem_cas_n | output | 4 | Column strobes, active low |
| mem_we_n | output | 1 | Write enable, active low |
| mem_dq_o | output | 64 | Data to memory |
| mem_dq_oe | output | 1 | Drive enable for the data pins |
| mem_dq_i | input | 64 | Data from memory |
| mem_par_o | output | 2 | Parity to memory |
| mem_par_i | input | 2 | Parity from memory |

## Verification
Several properties are checked on every cycle: that no two banks have their row strobe low outside refresh, that a write never occurs without exactly one open bank, that every all-bank row strobe is preceded by all column strobes low, that ready never coincides with an active strobe, and that a parity error never appears without read data. The refresh timer's pending flag is also checked never to drop except on acknowledgement. Other behaviour can only be shown by the bench's scenarios: the exact address split for each bank size, the phase lengths, the refresh period, the ordering of a refresh against a waiting request, and self-refresh entry and exit.

// File: rtl/dramc_pkg.sv
package dramc_pkg;
  localparam int ADDR_W = 28;
  localparam int DATA_W = 64;
  localparam int HALF_W = 32;
  localparam int N_HALF = DATA_W / HALF_W;
  localparam int N_BANK = 8;
  localparam int BANK_W = $clog2(N_BANK);
  localparam int LOC_W  = 11;
  localparam int MA_W   = 12;
  localparam int N_CAS  = 4;
  localparam int PH_W   = 3;
  localparam int REF_W  = 16;

  typedef enum logic [3:0] {
    ST_IDLE, ST_ROW, ST_ACT, ST_COL, ST_CAS, ST_PRE, ST_RCAS, ST_RRAS, ST_SELF
  } dc_state_e;

  typedef struct packed {
    logic [BANK_W-1:0] bank;
    logic [LOC_W-1:0]  row;
    logic [LOC_W-1:0]  col;
  } dc_loc_t;
endpackage

// File: rtl/dram_bank_map.sv
module dram_bank_map
  import dramc_pkg::*;
(
  input  logic [ADDR_W-1:0] addr,
  input  logic [1:0]        size_sel,
  output dc_loc_t           loc
);
  localparam int WORD_W = ADDR_W - 3;
  logic [WORD_W-1:0] w;
  logic [2:0]        unused_byte;

  assign w = addr[ADDR_W-1:3];
  assign unused_byte = addr[2:0];

  always_comb begin
    case (size_sel)
      2'd0: begin
        loc.col  = {2'b00, w[8:0]};
        loc.row  = {2'b00, w[17:9]};
        loc.bank = w[20:18];
      end
      2'd1: begin
        loc.col  = {1'b0, w[9:0]};
        loc.row  = {1'b0, w[19:10]};
        loc.bank = w[22:20];
      end
      default: begin
        loc.col  = w[10:0];
        loc.row  = w[21:11];
        loc.bank = w[24:22];
      end
    endcase
  end
endmodule

// File: rtl/dram_parity.sv
module dram_parity
  import dramc_pkg::*;
#(
  parameter bit PAR_ODD = 1'b0
) (
  input  logic [DATA_W-1:0] wdata,
  output logic [N_HALF-1:0] wpar,
  input  logic [DATA_W-1:0] rdata,
  input  logic [N_HALF-1:0] rpar,
  output logic [N_HALF-1:0] mismatch
);
  for (genvar h = 0; h < N_HALF; h++) begin : g_half
    assign wpar[h]     = (^wdata[h*HALF_W +: HALF_W]) ^ PAR_ODD;
    assign mismatch[h] = (^rdata[h*HALF_W +: HALF_W]) ^ PAR_ODD ^ rpar[h];
  end
endmodule

// File: rtl/dram_refresh_timer.sv
module dram_refresh_timer
  import dramc_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic [REF_W-1:0] interval,
  input  logic             hold,
  input  logic             ack,
  output logic             pending
);
  logic [REF_W-1:0] cnt_q, cnt_d;
  logic             pend_d, hit;

  assign hit = (interval != '0) && !hold && (cnt_q == interval - 1'b1);

  always_comb begin
    cnt_d  = cnt_q;
    pend_d = pending;
    if (interval == '0 || hold) cnt_d = '0;
    else if (hit)               cnt_d = '0;
    else                        cnt_d = cnt_q + 1'b1;
    if (hit)      pend_d = 1'b1;
    else if (ack) pend_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q   <= '0;
      pending <= 1'b0;
    end else begin
      cnt_q   <= cnt_d;
      pending <= pend_d;
    end
  end

  // R9: a due refresh is only withdrawn by the controller's acknowledgement
  a_r9_pending_held: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(pending) |-> $past(ack));
endmodule

// File: rtl/dram_ctl.sv
module dram_ctl
  import dramc_pkg::*;
#(
  parameter bit PAR_ODD = 1'b0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [1:0]        cfg_bank_size,
  input  logic [PH_W-1:0]   cfg_cas_hold,
  input  logic [PH_W-1:0]   cfg_precharge,
  input  logic [REF_W-1:0]  cfg_ref_interval,
  input  logic              cfg_self_refresh,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [N_HALF-1:0] req_wmask,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              rd_valid,
  output logic [DATA_W-1:0] rd_data,
  output logic [N_HALF-1:0] rd_par_err,
  output logic [MA_W-1:0]   mem_addr,
  output logic [N_BANK-1:0] mem_ras_n,
  output logic [N_CAS-1:0]  mem_cas_n,
  output logic              mem_we_n,
  output logic [DATA_W-1:0] mem_dq_o,
  output logic              mem_dq_oe,
  input  logic [DATA_W-1:0] mem_dq_i,
  output logic [N_HALF-1:0] mem_par_o,
  input  logic [N_HALF-1:0] mem_par_i
);
  localparam int CAS_PER_HALF = N_CAS / N_HALF;

  dc_state_e         state_q, state_d;
  logic [PH_W-1:0]   cnt_q, cnt_d, n_cas, n_pre;
  dc_loc_t           loc_dec, loc_q;
  logic              wr_q;
  logic [N_HALF-1:0] wmask_q, mism;
  logic [DATA_W-1:0] wdata_q;
  logic              ref_pend, ref_ack, load_en, rd_cap;

  dram_bank_map u_map (.addr(req_addr), .size_sel(cfg_bank_size), .loc(loc_dec));

  dram_parity #(.PAR_ODD(PAR_ODD)) u_par (
    .wdata(wdata_q), .wpar(mem_par_o), .rdata(mem_dq_i), .rpar(mem_par_i), .mismatch(mism));

  dram_refresh_timer u_ref (
    .clk(clk), .rst_n(rst_n), .interval(cfg_ref_interval),
    .hold(cfg_self_refresh || state_q == ST_SELF), .ack(ref_ack), .pending(ref_pend));

  assign n_cas = (cfg_cas_hold == '0)  ? PH_W'(1) : cfg_cas_hold;
  assign n_pre = (cfg_precharge == '0) ? PH_W'(1) : cfg_precharge;

  assign req_ready = (state_q == ST_IDLE) && !cfg_self_refresh && !ref_pend;
  assign load_en   = req_ready && req_valid;
  assign rd_cap    = (state_q == ST_CAS) && (cnt_q == '0) && !wr_q;

  // next state
  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    ref_ack = 1'b0;
    case (state_q)
      ST_IDLE: begin
        if (cfg_self_refresh || ref_pend) begin
          state_d = ST_RCAS;
          ref_ack = 1'b1;
        end else if (req_valid) begin
          state_d = ST_ROW;
        end
      end
      ST_ROW: state_d = ST_ACT;
      ST_ACT: state_d = ST_COL;
      ST_COL: begin
        state_d = ST_CAS;
        cnt_d   = n_cas - 1'b1;
      end
      ST_CAS, ST_RRAS: begin
        if (cnt_q == '0) begin
          state_d = ST_PRE;
          cnt_d   = n_pre - 1'b1;
        end else begin
          cnt_d = cnt_q - 1'b1;
        end
      end
      ST_PRE: begin
        if (cnt_q == '0) state_d = ST_IDLE;
        else             cnt_d   = cnt_q - 1'b1;
      end
      ST_RCAS: begin
        if (cfg_self_refresh) begin
          state_d = ST_SELF;
        end else begin
          state_d = ST_RRAS;
          cnt_d   = n_cas - 1'b1;
        end
      end
      ST_SELF: begin
        if (!cfg_self_refresh) begin
          state_d = ST_PRE;
          cnt_d   = n_pre - 1'b1;
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  // control registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q    <= ST_IDLE;
      cnt_q      <= '0;
      rd_valid   <= 1'b0;
      rd_par_err <= '0;
    end else begin
      state_q    <= state_d;
      cnt_q      <= cnt_d;
      rd_valid   <= rd_cap;
      rd_par_err <= rd_cap ? mism : '0;
    end
  end

  // datapath registers, clock-enabled, no reset
  always_ff @(posedge clk) begin
    if (load_en) begin
      loc_q   <= loc_dec;
      wr_q    <= req_write;
      wmask_q <= req_wmask;
      wdata_q <= req_wdata;
    end
    if (rd_cap) rd_data <= mem_dq_i;
  end

  // pin drive
  always_comb begin
    mem_addr  = '0;
    mem_ras_n = '1;
    mem_cas_n = '1;
    case (state_q)
      ST_ROW:          mem_addr = MA_W'(loc_q.row);
      ST_ACT: begin
        mem_addr  = MA_W'(loc_q.row);
        mem_ras_n = ~(N_BANK'(1) << loc_q.bank);
      end
      ST_COL: begin
        mem_addr  = MA_W'(loc_q.col);
        mem_ras_n = ~(N_BANK'(1) << loc_q.bank);
      end
      ST_CAS: begin
        mem_addr  = MA_W'(loc_q.col);
        mem_ras_n = ~(N_BANK'(1) << loc_q.bank);
        for (int c = 0; c < N_CAS; c++)
          mem_cas_n[c] = wr_q ? !wmask_q[c / CAS_PER_HALF] : 1'b0;
      end
      ST_RCAS:         mem_cas_n = '0;
      ST_RRAS, ST_SELF: begin
        mem_cas_n = '0;
        mem_ras_n = '0;
      end
      default: ;
    endcase
  end

  assign mem_dq_oe = wr_q && (state_q == ST_COL || state_q == ST_CAS);
  assign mem_we_n  = !mem_dq_oe;
  assign mem_dq_o  = wdata_q;

  // R3: at most one open bank, unless every bank is strobed for refresh
  a_r3_one_bank: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_ras_n == '0) || ($countones(~mem_ras_n) <= 1));
  // R4: a write strobe needs exactly one open bank
  a_r4_write_bank: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_we_n |-> ($countones(~mem_ras_n) == 1));
  // R8: all-bank row strobe is preceded by all column strobes low
  a_r8_cas_first: assert property (@(posedge clk) disable iff (!rst_n)
    ((mem_ras_n == '0) && ($past(mem_ras_n) == '1)) |-> ($past(mem_cas_n) == '0));
  // R10: ready only while the array is quiet
  a_r10_ready_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> ((mem_ras_n == '1) && (mem_cas_n == '1)));
  // R7: a parity flag only travels with read data
  a_r7_err_with_data: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_par_err != '0) |-> rd_valid);
endmodule

// File: tb/tb_dram_ctl.sv
module tb_dram_ctl;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [1:0]  cfg_bank_size = 2'd0;
  logic [2:0]  cfg_cas_hold = 3'd2;
  logic [2:0]  cfg_precharge = 3'd2;
  logic [15:0] cfg_ref_interval = 16'd0;
  logic        cfg_self_refresh = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic        req_write = 1'b0;
  logic [27:0] req_addr = '0;
  logic [1:0]  req_wmask = '0;
  logic [63:0] req_wdata = '0;
  logic        rd_valid;
  logic [63:0] rd_data;
  logic [1:0]  rd_par_err;
  logic [11:0] mem_addr;
  logic [7:0]  mem_ras_n;
  logic [3:0]  mem_cas_n;
  logic        mem_we_n;
  logic [63:0] mem_dq_o;
  logic        mem_dq_oe;
  logic [63:0] mem_dq_i = '0;
  logic [1:0]  mem_par_o;
  logic [1:0]  mem_par_i = '0;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  dram_ctl dut (.*);

  task automatic chk(input logic ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  function automatic logic [1:0] par_of(input logic [63:0] d);
    return {^d[63:32], ^d[31:0]};
  endfunction

  // one access; keep=1 leaves req_valid high afterwards
  task automatic access(input logic wr, input logic [1:0] sz, input int bank, input int row, input int col,
                        input logic [1:0] mask, input logic [63:0] data, input logic [1:0] par_flip,
                        input bit keep);
    int h = 9 + sz;
    int n = (cfg_cas_hold == 0) ? 1 : cfg_cas_hold;
    int p = (cfg_precharge == 0) ? 1 : cfg_precharge;
    logic [27:0] a;
    logic [3:0] exp_cas;
    a = 28'((((longint'(bank) << (2*h)) | (longint'(row) << h) | col) << 3) | 5);
    if (sz == 0) a[27] = 1'b1;   // above the bank field: ignored (R2)
    exp_cas = wr ? {~mask[1], ~mask[1], ~mask[0], ~mask[0]} : 4'b0000;
    @(negedge clk);
    cfg_bank_size = sz; req_valid = 1'b1; req_write = wr; req_addr = a;
    req_wmask = mask; req_wdata = data;
    mem_dq_i = ~data; mem_par_i = par_of(~data) ^ par_flip;
    while (!req_ready) @(negedge clk);
    @(negedge clk);
    if (!keep) req_valid = 1'b0;
    chk(mem_ras_n == 8'hFF && mem_addr == 12'(row), "R3 row phase", {mem_ras_n, mem_addr}, {8'hFF, 12'(row)});
    @(negedge clk);
    chk(mem_ras_n == ~(8'd1 << bank) && mem_addr == 12'(row), "R2 bank/row", {mem_ras_n, mem_addr},
        {~(8'd1 << bank), 12'(row)});
    @(negedge clk);
    chk(mem_addr == 12'(col) && mem_cas_n == 4'hF && mem_we_n == !wr, "R2 column", {mem_addr, mem_cas_n, 3'b0, mem_we_n},
        {12'(col), 4'hF, 3'b0, !wr});
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      chk(mem_cas_n == exp_cas && mem_ras_n == ~(8'd1 << bank), "R4 cas phase", {mem_cas_n, mem_ras_n},
          {exp_cas, ~(8'd1 << bank)});
      if (wr) begin
        chk(!mem_we_n && mem_dq_oe && mem_dq_o == data, "R4 write drive", mem_dq_o, data);
        chk(mem_par_o == par_of(data), "R6 write parity", mem_par_o, par_of(data));
      end
      chk(rd_valid == 1'b0, "R5 no early valid", rd_valid, 0);
    end
    for (int i = 0; i < p; i++) begin
      @(negedge clk);
      chk(mem_ras_n == 8'hFF && mem_cas_n == 4'hF && mem_we_n, "R3 precharge", {mem_ras_n, mem_cas_n}, 12'hFFF);
      if (i == 0 && !wr) begin
        chk(rd_valid && rd_data == ~data, "R5 read data", rd_data, ~data);
        chk(rd_par_err == par_flip, "R7 parity check", rd_par_err, par_flip);
      end else begin
        chk(!rd_valid && rd_par_err == 2'b00, "R5 single pulse", {rd_valid, rd_par_err}, 0);
      end
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(mem_ras_n == 8'hFF && mem_cas_n == 4'hF && mem_we_n, "R1 strobes in reset", {mem_ras_n, mem_cas_n}, 12'hFFF);
    rst_n = 1'b1;
    @(negedge clk);
    chk(req_ready && !rd_valid, "R1 ready after reset", {req_ready, rd_valid}, 2'b10);

    // sweep sizes, banks, directions
    for (int sz = 0; sz < 3; sz++) begin
      for (int b = 0; b < 8; b++) begin
        int h = 9 + sz;
        int row = ((b * 173 + sz * 59 + 1) * 7) & ((1 << h) - 1);
        int col = (b * 91 + sz * 301 + ((1 << h) - 2)) & ((1 << h) - 1);
        logic [63:0] d = {32'(b * 32'h01010101 + sz), 32'(32'hA5A50000 ^ (b << 4))};
        access(1'b0, 2'(sz), b, row, col, 2'b00, d, 2'(b % 4), 1'b0);
        access(1'b1, 2'(sz), b, col, row, 2'(b % 3 + 1), ~d, 2'b00, 1'b0);
      end
    end

    // phase lengths: hold 0 acts as 1, precharge 3
    cfg_cas_hold = 3'd0; cfg_precharge = 3'd3;
    access(1'b0, 2'd2, 5, 12'h7FF & 2047, 0, 2'b00, 64'h0123456789ABCDEF, 2'b11, 1'b0);
    access(1'b1, 2'd1, 3, 1023, 1023, 2'b11, 64'hFFFF0000FFFF0001, 2'b00, 1'b0);
    cfg_cas_hold = 3'd2; cfg_precharge = 3'd2;

    // R9: periodic refresh, interval 16, plus full R8 shape
    begin
      int t = 0, n_seen = 0, last = 0;
      @(negedge clk);
      cfg_ref_interval = 16'd16;
      while (n_seen < 4 && t < 200) begin
        @(negedge clk); t++;
        if (mem_cas_n == 4'h0 && mem_ras_n == 8'hFF) begin
          if (n_seen > 0) chk(t - last == 16, "R9 refresh period", 64'(t - last), 16);
          if (n_seen == 0) begin
            for (int i = 0; i < 2; i++) begin
              @(negedge clk); t++;
              chk(mem_ras_n == 8'h00 && mem_cas_n == 4'h0 && mem_we_n, "R8 all banks strobed",
                  {mem_ras_n, mem_cas_n}, 0);
            end
            for (int i = 0; i < 2; i++) begin
              @(negedge clk); t++;
              chk(mem_ras_n == 8'hFF && mem_cas_n == 4'hF, "R8 refresh precharge", {mem_ras_n, mem_cas_n}, 12'hFFF);
            end
            last = t - 4;
          end else begin
            last = t;
          end
          n_seen++;
        end
      end
      chk(n_seen == 4, "R9 refresh count", 64'(n_seen), 4);
      cfg_ref_interval = 16'd0;
      repeat (20) @(negedge clk);
      n_seen = 0;
      for (int i = 0; i < 100; i++) begin
        @(negedge clk);
        if (mem_cas_n != 4'hF) n_seen++;
      end
      chk(n_seen == 0, "R9 interval zero disables", 64'(n_seen), 0);
    end

    // R10: refresh due mid-access goes before the waiting request
    @(negedge clk);
    cfg_ref_interval = 16'd4;
    access(1'b0, 2'd0, 2, 17, 33, 2'b00, 64'h55AA55AA00FF00FF, 2'b00, 1'b1);
    @(negedge clk);
    chk(!req_ready && mem_ras_n == 8'hFF && mem_cas_n == 4'hF, "R10 ready low while due",
        {req_ready, mem_ras_n, mem_cas_n}, {1'b0, 12'hFFF});
    @(negedge clk);
    chk(mem_cas_n == 4'h0 && mem_ras_n == 8'hFF, "R10 refresh precedes request", {mem_cas_n, mem_ras_n}, 12'h0FF);
    req_valid = 1'b0; cfg_ref_interval = 16'd0;
    while (!req_ready) @(negedge clk);

    // R11: self refresh
    cfg_self_refresh = 1'b1;
    @(negedge clk);
    chk(mem_cas_n == 4'h0 && mem_ras_n == 8'hFF, "R11 entry cas first", {mem_cas_n, mem_ras_n}, 12'h0FF);
    req_valid = 1'b1;
    for (int i = 0; i < 6; i++) begin
      @(negedge clk);
      chk(mem_cas_n == 4'h0 && mem_ras_n == 8'h00 && !req_ready, "R11 held low", {req_ready, mem_cas_n, mem_ras_n}, 0);
    end
    req_valid = 1'b0;
    cfg_self_refresh = 1'b0;
    for (int i = 0; i < 2; i++) begin
      @(negedge clk);
      chk(mem_cas_n == 4'hF && mem_ras_n == 8'hFF && !req_ready, "R11 exit precharge",
          {req_ready, mem_cas_n, mem_ras_n}, 12'hFFF);
    end
    @(negedge clk);
    chk(req_ready, "R11 ready after exit", req_ready, 1);
    access(1'b0, 2'd2, 7, 2047, 2047, 2'b00, 64'hDEADBEEFCAFEF00D, 2'b01, 1'b0);

    done = 1'b1;
  end

  initial begin
    for (int c = 0; c < 20000 && !done; c++) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual timeout expected completion");
    end
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule